// File: doc/BRIEF.md
# SDRAM Clock-Enable Power-State Controller

This block is the device-side clock-enable logic of a single-data-rate SDRAM. On every rising clock edge it samples the clock-enable pin and the command pins (chip select, row strobe, column strobe, write enable). It also takes a per-bank open-row vector and a burst-in-progress flag from the rest of the device. From these it steps between normal operation, two kinds of power-down and clock suspend.

The clock-enable pin means different things in different contexts. Sampled low while a column burst runs, it freezes the internal clock for the next edge. Sampled low at idle together with a no-operation or deselect command, it enters power-down. The power-down is called precharge power-down when all banks are closed, and active power-down when any row is open.

The outputs drive the rest of the device. One is an internal clock enable that gates downstream synchronous logic. The others are a burst-counter advance strobe, an input-buffer enable, a DQ hold request and a command-fire strobe. The block also reports a 2-bit state code, a pulse for an attempted power-down entry with a real command, and a flag raised when power-down has lasted past a configurable cycle budget that stands for the refresh interval. All control pins are plain level signals with no handshake.

Top module: `sdram_cke_ctrl`

## Requirements
- R1: After reset the state code is 00 (normal), the internal clock enable and input-buffer enable are 1, and the illegal-entry and refresh-violation flags are 0.
- R2: In normal state, with CKE sampled low, no burst in progress, no bank open and an idle command, the state code is 01 (precharge power-down) from the next cycle. Idle commands are deselect (cs_n=1) or NOP (cs_n=0, ras_n=cas_n=we_n=1). Internal clock enable and input-buffer enable are then 0.
- R3: The same entry with at least one bit of the open-row vector set gives state code 10 (active power-down).
- R4: In normal state, CKE sampled low with no burst and a non-idle command does not change the state. illegal_entry_o is 1 for exactly the following cycle.
- R5: While powered down, non-idle commands are ignored. cmd_fire_o stays 0, and CKE high with a non-idle command does not leave power-down.
- R6: While powered down, CKE sampled high with an idle command returns the state code to 00 on the next cycle.
- R7: In normal state, CKE sampled low while a burst is in progress gives state code 11 (clock suspend) from the next cycle, whatever the command or bank state. In that state clk_en_o=0, dq_hold_o=1, burst_adv_o=0 and cmd_fire_o=0.
- R8: In clock suspend, CKE sampled high returns to state 00 on the next cycle. A single low sample of CKE therefore suppresses exactly one internal edge.
- R9: refresh_viol_o rises when more than PD_LIMIT rising edges have passed in power-down since entry. It is 0 at exactly PD_LIMIT edges and clears when power-down is left.
- R10: cmd_fire_o is 1 only when the internal clock is enabled and the command is non-idle.
- R11: burst_adv_o is 1 only when the internal clock is enabled and a burst is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Device clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cke_i | input | 1 | Clock-enable pin |
| cs_n_i | input | 1 | Chip select, active low |
| ras_n_i | input | 1 | Row strobe, active low |
| cas_n_i | input | 1 | Column strobe, active low |
| we_n_i | input | 1 | Write enable, active low |
| row_open_i | input | NUM_BANKS | One bit per bank holding an open row |
| burst_busy_i | input | 1 | A column access or burst is in progress |
| clk_en_o | output | 1 | Internal clock enable for downstream logic |
| burst_adv_o | output | 1 | Burst counter advance strobe |
| inbuf_en_o | output | 1 | Input/output buffer enable |
| dq_hold_o | output | 1 | DQ outputs keep their current value |
| cmd_fire_o | output | 1 | A real command is accepted this cycle |
| pwr_state_o | output | 2 | 00 normal, 01 precharge PD, 10 active PD, 11 suspend |
| illegal_entry_o | output | 1 | Pulse: CKE low at idle with a non-idle command |
| refresh_viol_o | output | 1 | Power-down exceeded the refresh budget |

## Verification
The stimulus table sends CKE low from normal state four ways: idle command with all banks closed, idle command with a row open, real command at idle, and any command during a burst. These cases separate the two power-down modes from suspend and from the rejected entry. Exit patterns pair CKE high with both idle and non-idle commands, which tells a real exit from an ignored command. A case with a burst and an open row together checks that suspend takes priority. Directed tests walk the power-down timer across its PD_LIMIT boundary and probe the combinational strobes inside and outside suspend.

// File: rtl/sdram_cke_pkg.sv
package sdram_cke_pkg;

  typedef enum logic [1:0] {
    ST_NORMAL = 2'b00,
    ST_PPD    = 2'b01,
    ST_APD    = 2'b10,
    ST_SUSP   = 2'b11
  } pwr_state_e;

  typedef struct packed {
    logic idle;   // deselect or NOP
    logic real_c; // any other command
  } cmd_class_t;

  function automatic logic is_pd(pwr_state_e s);
    return (s == ST_PPD) || (s == ST_APD);
  endfunction

endpackage

// File: rtl/cke_cmd_decode.sv
module cke_cmd_decode
  import sdram_cke_pkg::*;
(
  input  logic       cs_n,
  input  logic       ras_n,
  input  logic       cas_n,
  input  logic       we_n,
  output cmd_class_t cls
);
  logic deselect;
  logic nop;

  always_comb begin
    deselect   = cs_n;
    nop        = !cs_n && ras_n && cas_n && we_n;
    cls.idle   = deselect || nop;
    cls.real_c = !(deselect || nop);
  end
endmodule

// File: rtl/cke_state_fsm.sv
module cke_state_fsm
  import sdram_cke_pkg::*;
#(
  parameter int NUM_BANKS = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cke,
  input  cmd_class_t           cls,
  input  logic [NUM_BANKS-1:0] row_open,
  input  logic                 burst_busy,
  output pwr_state_e           state_q,
  output pwr_state_e           state_d,
  output logic                 illegal_q
);
  logic any_open;
  logic illegal_d;

  assign any_open = |row_open;

  always_comb begin
    state_d   = state_q;
    illegal_d = 1'b0;
    unique case (state_q)
      ST_NORMAL: begin
        if (!cke) begin
          if (burst_busy) begin
            state_d = ST_SUSP;
          end else if (cls.idle) begin
            state_d = any_open ? ST_APD : ST_PPD;
          end else begin
            illegal_d = 1'b1;
          end
        end
      end
      ST_PPD, ST_APD: begin
        if (cke && cls.idle) state_d = ST_NORMAL;
      end
      ST_SUSP: begin
        if (cke) state_d = ST_NORMAL;
      end
      default: state_d = ST_NORMAL;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_NORMAL;
      illegal_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      illegal_q <= illegal_d;
    end
  end
endmodule

// File: rtl/cke_pd_timer.sv
module cke_pd_timer #(
  parameter int PD_LIMIT = 8533333
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pd_now,
  input  logic pd_next,
  output logic viol
);
  localparam int CNT_W = $clog2(PD_LIMIT + 2);
  localparam logic [CNT_W-1:0] SAT = CNT_W'(PD_LIMIT + 1);
  localparam logic [CNT_W-1:0] LIM = CNT_W'(PD_LIMIT);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!pd_next) begin
      cnt_q <= '0;
    end else if (pd_now && cnt_q != SAT) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign viol = pd_now && (cnt_q > LIM);
endmodule

// File: rtl/sdram_cke_ctrl.sv
module sdram_cke_ctrl
  import sdram_cke_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int PD_LIMIT  = 8533333
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cke_i,
  input  logic                 cs_n_i,
  input  logic                 ras_n_i,
  input  logic                 cas_n_i,
  input  logic                 we_n_i,
  input  logic [NUM_BANKS-1:0] row_open_i,
  input  logic                 burst_busy_i,
  output logic                 clk_en_o,
  output logic                 burst_adv_o,
  output logic                 inbuf_en_o,
  output logic                 dq_hold_o,
  output logic                 cmd_fire_o,
  output logic [1:0]           pwr_state_o,
  output logic                 illegal_entry_o,
  output logic                 refresh_viol_o
);
  cmd_class_t cls;
  pwr_state_e state_q;
  pwr_state_e state_d;

  cke_cmd_decode u_dec (
    .cs_n  (cs_n_i),
    .ras_n (ras_n_i),
    .cas_n (cas_n_i),
    .we_n  (we_n_i),
    .cls   (cls)
  );

  cke_state_fsm #(.NUM_BANKS(NUM_BANKS)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .cke        (cke_i),
    .cls        (cls),
    .row_open   (row_open_i),
    .burst_busy (burst_busy_i),
    .state_q    (state_q),
    .state_d    (state_d),
    .illegal_q  (illegal_entry_o)
  );

  cke_pd_timer #(.PD_LIMIT(PD_LIMIT)) u_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .pd_now  (is_pd(state_q)),
    .pd_next (is_pd(state_d)),
    .viol    (refresh_viol_o)
  );

  always_comb begin
    clk_en_o    = (state_q == ST_NORMAL);
    inbuf_en_o  = !is_pd(state_q);
    dq_hold_o   = (state_q == ST_SUSP);
    burst_adv_o = clk_en_o && burst_busy_i;
    cmd_fire_o  = clk_en_o && cls.real_c;
    pwr_state_o = state_q;
  end
endmodule

// File: rtl/sdram_cke_ctrl_chk.sv
module sdram_cke_ctrl_chk #(
  parameter int NUM_BANKS = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cke_i,
  input logic                 cs_n_i,
  input logic                 ras_n_i,
  input logic                 cas_n_i,
  input logic                 we_n_i,
  input logic [NUM_BANKS-1:0] row_open_i,
  input logic                 burst_busy_i,
  input logic                 clk_en_o,
  input logic                 burst_adv_o,
  input logic                 inbuf_en_o,
  input logic                 dq_hold_o,
  input logic                 cmd_fire_o,
  input logic [1:0]           pwr_state_o,
  input logic                 illegal_entry_o,
  input logic                 refresh_viol_o
);
  logic idle_c;
  logic nrm;
  logic pd;
  assign idle_c = cs_n_i || (ras_n_i && cas_n_i && we_n_i);
  assign nrm    = (pwr_state_o == 2'b00);
  assign pd     = (pwr_state_o == 2'b01) || (pwr_state_o == 2'b10);

  assert_ppd_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
    nrm && !cke_i && !burst_busy_i && idle_c && (row_open_i == '0) |=> pwr_state_o == 2'b01);
  assert_apd_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
    nrm && !cke_i && !burst_busy_i && idle_c && (row_open_i != '0) |=> pwr_state_o == 2'b10);
  assert_illegal_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
    nrm && !cke_i && !burst_busy_i && !idle_c |=> nrm && illegal_entry_o);
  assert_pd_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pd && !(cke_i && idle_c) |=> $stable(pwr_state_o));
  assert_pd_buffers_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pd |-> !inbuf_en_o && !cmd_fire_o);
  assert_pd_exit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pd && cke_i && idle_c |=> nrm);
  assert_suspend_entry_R7: assert property (@(posedge clk) disable iff (!rst_n)
    nrm && !cke_i && burst_busy_i |=> pwr_state_o == 2'b11 && dq_hold_o);
  assert_suspend_exit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state_o == 2'b11) && cke_i |=> nrm);
  assert_viol_in_pd_R9: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_viol_o |-> pd);
  assert_fire_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en_o |-> !cmd_fire_o);
  assert_adv_gated_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en_o |-> !burst_adv_o);
endmodule

bind sdram_cke_ctrl sdram_cke_ctrl_chk #(.NUM_BANKS(NUM_BANKS)) chk_i (
  .clk             (clk),
  .rst_n           (rst_n),
  .cke_i           (cke_i),
  .cs_n_i          (cs_n_i),
  .ras_n_i         (ras_n_i),
  .cas_n_i         (cas_n_i),
  .we_n_i          (we_n_i),
  .row_open_i      (row_open_i),
  .burst_busy_i    (burst_busy_i),
  .clk_en_o        (clk_en_o),
  .burst_adv_o     (burst_adv_o),
  .inbuf_en_o      (inbuf_en_o),
  .dq_hold_o       (dq_hold_o),
  .cmd_fire_o      (cmd_fire_o),
  .pwr_state_o     (pwr_state_o),
  .illegal_entry_o (illegal_entry_o),
  .refresh_viol_o  (refresh_viol_o)
);

// File: tb/sdram_cke_ctrl_tb.sv
module sdram_cke_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NB         = 4;
  localparam int LIMIT      = 10;
  localparam int NVEC       = 16;

  // vector: {cke, ctype[1:0], row, busy, exp_state[1:0], exp_ill}
  // ctype: 0 NOP, 1 deselect, 2 activate-like, 3 read-like
  localparam logic [7:0] VEC [NVEC] = '{
    8'b1000_0000, // stay normal
    8'b0000_0010, // R2 precharge PD
    8'b0110_0010, // R5 command ignored
    8'b1110_0010, // R5 cke high + real cmd: no exit
    8'b1010_0000, // R6 exit on deselect
    8'b0100_0001, // R4 illegal entry
    8'b1000_0000, // R4 pulse ends
    8'b0011_0100, // R3 active PD
    8'b1001_0000, // R6 exit
    8'b0110_1110, // R7 suspend on burst
    8'b0000_1110, // R7 stays suspended
    8'b1000_1000, // R8 resume
    8'b0001_1110, // R7 burst wins over open row
    8'b1110_1000, // R8 resume
    8'b0010_0010, // R2 via deselect
    8'b1000_0000  // R6 exit
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cke, cs_n, ras_n, cas_n, we_n, busy;
  logic [NB-1:0] rows;
  logic clk_en, adv, inbuf, hold, fire, ill, viol;
  logic [1:0] st;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdram_cke_ctrl #(.NUM_BANKS(NB), .PD_LIMIT(LIMIT)) dut_i (
    .clk(clk), .rst_n(rst_n), .cke_i(cke), .cs_n_i(cs_n), .ras_n_i(ras_n),
    .cas_n_i(cas_n), .we_n_i(we_n), .row_open_i(rows), .burst_busy_i(busy),
    .clk_en_o(clk_en), .burst_adv_o(adv), .inbuf_en_o(inbuf), .dq_hold_o(hold),
    .cmd_fire_o(fire), .pwr_state_o(st), .illegal_entry_o(ill),
    .refresh_viol_o(viol)
  );

  task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic drive(input logic k, input logic [1:0] ct, input logic r, input logic b);
    cke  = k;
    rows = r ? NB'(4) : '0;
    busy = b;
    case (ct)
      2'd0: {cs_n, ras_n, cas_n, we_n} = 4'b0111;
      2'd1: {cs_n, ras_n, cas_n, we_n} = 4'b1111;
      2'd2: {cs_n, ras_n, cas_n, we_n} = 4'b0011;
      default: {cs_n, ras_n, cas_n, we_n} = 4'b0101;
    endcase
  endtask

  task automatic step;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    drive(1'b1, 2'd0, 1'b0, 1'b0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 state", {2'b0, st}, 4'h0);
    chk("R1 enables", {2'b0, clk_en, inbuf}, 4'h3);
    chk("R1 flags", {2'b0, ill, viol}, 4'h0);

    for (int i = 0; i < NVEC; i++) begin
      logic [7:0] v;
      logic [1:0] es;
      v  = VEC[i];
      es = v[2:1];
      drive(v[7], v[6:5], v[4], v[3]);
      step();
      chk($sformatf("R2-table step %0d state", i), {2'b0, st}, {2'b0, es});
      chk($sformatf("R4-table step %0d illegal", i), {3'b0, ill}, {3'b0, v[0]});
      chk($sformatf("R7-table step %0d clk_en/inbuf", i), {2'b0, clk_en, inbuf},
          {2'b0, es == 2'b00, !(es == 2'b01 || es == 2'b10)});
    end

    // R9 refresh budget
    drive(1'b0, 2'd0, 1'b0, 1'b0);
    step();
    chk("R9 entered PD", {2'b0, st}, 4'h1);
    for (int k = 1; k <= LIMIT; k++) begin
      step();
      chk($sformatf("R9 no viol at %0d", k), {3'b0, viol}, 4'h0);
    end
    step();
    chk("R9 viol past limit", {3'b0, viol}, 4'h1);
    step();
    chk("R9 viol holds", {3'b0, viol}, 4'h1);
    drive(1'b1, 2'd1, 1'b0, 1'b0);
    step();
    chk("R9 cleared on exit", {2'b0, viol, st == 2'b00}, 4'h1);

    // R10 / R11 strobes in normal
    drive(1'b1, 2'd3, 1'b0, 1'b1);
    #1;
    chk("R10 fire in normal", {3'b0, fire}, 4'h1);
    chk("R11 adv in normal", {3'b0, adv}, 4'h1);
    drive(1'b1, 2'd0, 1'b0, 1'b1);
    #1;
    chk("R10 NOP no fire", {3'b0, fire}, 4'h0);

    // R7 / R8 single low sample suppresses one edge
    drive(1'b0, 2'd3, 1'b0, 1'b1);
    step();
    drive(1'b1, 2'd3, 1'b0, 1'b1);
    #1;
    chk("R7 suspend outputs", {fire, adv, hold, clk_en}, 4'b0010);
    step();
    chk("R8 resumed after one edge", {fire, adv, hold, clk_en}, 4'b1101);

    // R5 fire blocked in PD
    drive(1'b0, 2'd0, 1'b0, 1'b0);
    step();
    drive(1'b1, 2'd2, 1'b0, 1'b0);
    #1;
    chk("R5 fire blocked in PD", {2'b0, fire, inbuf}, 4'h0);
    step();
    chk("R5 still in PD", {2'b0, st}, 4'h1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule